// File: doc/BRIEF.md
# Timeslot Serial Data Port

This block carries parallel 16-bit words over a frame-synchronous serial link. A bit clock (DCL) and a frame sync (FSC), both already in the system clock domain, arrive from an internal clock generator or from external pins. The port detects their edges with the system clock. A frame begins at the first DCL rising edge that finds FSC high after it was low on the previous rising edge. The frame is split into 16-bit timeslots. For each active slot the port takes one word from `tx_data` and shifts it out on `txd`, most significant bit first. In the same slot it gathers 16 bits from `rxd` into a word and presents that word with a one-cycle strobe.

A mode input sets the bit cell. In single-cell mode one DCL cycle carries one bit. The bit is launched on the rising edge and sampled on the falling edge. In double-cell mode one bit spans two DCL cycles. It is launched on the first rising edge and sampled on the second falling edge. A run-time slot count sets how many slots are active. It is limited to the `MAX_SLOTS` parameter: 12 suits an internal 1.536 MHz clock in single-cell mode, 6 suits double-cell mode, and up to 16 are used with an external clock. Clock generation and routing of slots to channels are done elsewhere.

Top module: `tsp_serial_port`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `txd` is 1 and `rx_valid` and `tx_take` are 0.
- R2: Before the first frame start, no word is taken or delivered and `txd` stays 1.
- R3: A frame starts on a DCL rising edge that finds FSC high after FSC was low on the previous DCL rising edge. That same edge launches bit 0 of slot 0.
- R4: In an active slot, bit k (k = 0 to 15, counted from the frame-aligned slot start) drives `txd` with `tx_data[15-k]` of the word taken for that slot. `txd` changes only after a DCL rising edge.
- R5: At the launch of bit 0 of each active slot, the port captures `tx_data` and pulses `tx_take` for one clock cycle, with `tx_take_slot` set to the slot index (slot 0 is the first after FSC).
- R6: Receive sampling happens on a DCL falling edge. In single-cell mode (`double_mode` = 0) every falling edge samples. In double-cell mode (`double_mode` = 1) only the second falling edge of each bit samples. The first bit received becomes bit 15 of the word.
- R7: After the 16th sample of an active slot, `rx_valid` is high for exactly one clock cycle, and `rx_word` and `rx_slot` hold the word and its slot index.
- R8: A slot whose index is at or above the active count keeps `txd` at 1 and raises neither `tx_take` nor `rx_valid`. An `active_slots` value above `MAX_SLOTS` acts as `MAX_SLOTS`, and 0 leaves every slot inactive.
- R9: A new frame start in the middle of a frame restarts slot 0 bit 0 at once. The partly received word is dropped without a strobe.
- R10: Once `MAX_SLOTS` slots have passed with no new frame start, the port stays idle (`txd` = 1, no strobes) until the next frame start.
- R11: In double-cell mode, `txd` keeps its value across the second DCL rising edge of a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dcl | input | 1 | Bit clock level, synchronous to clk |
| fsc | input | 1 | Frame sync level, synchronous to clk |
| double_mode | input | 1 | 0: one DCL cycle per bit, 1: two DCL cycles per bit |
| active_slots | input | 5 | Number of active timeslots per frame |
| tx_data | input | 16 | Word for the slot whose transmission starts next |
| tx_take | output | 1 | One-cycle pulse when `tx_data` is captured |
| tx_take_slot | output | 5 | Slot index belonging to `tx_take` |
| txd | output | 1 | Serial transmit data, 1 when idle |
| rxd | input | 1 | Serial receive data |
| rx_word | output | 16 | Last received word |
| rx_slot | output | 5 | Slot index of `rx_word` |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is new |

## Verification
Each slot gets a distinct transmit and receive word, so a slot that is shifted, swapped or reversed shows up as a mismatch in the scoreboard. In the receive stimulus `rxd` carries the inverted bit until just before the intended sampling edge. A design that samples on the rising edge, or on the first falling edge in double-cell mode, therefore collects wrong words. The frames cover both cell modes, several active counts (full, partial, zero and above the limit), a frame left to run past its last slot, and a frame cut short by an early FSC. Together these separate the slot limit, the clamp, the idle state after the last slot and the realignment on an early FSC.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    localparam int TSP_WORD_W = 16;
    localparam int TSP_BIT_W  = $clog2(TSP_WORD_W);
    localparam int TSP_SLOT_W = 5;

    typedef logic [TSP_WORD_W-1:0] word_t;
    typedef logic [TSP_SLOT_W-1:0] slot_t;
    typedef logic [TSP_BIT_W-1:0]  bitidx_t;

    typedef enum logic {
        CELL_SINGLE = 1'b0,
        CELL_DOUBLE = 1'b1
    } cell_mode_e;

    // Position within the frame; half marks the second DCL cycle of a double cell
    typedef struct packed {
        logic    in_frame;
        slot_t   slot;
        bitidx_t bitn;
        logic    half;
    } slot_pos_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic frame_start;
    } line_evt_t;

    localparam slot_pos_t POS_START = '{in_frame: 1'b1, slot: '0, bitn: '0, half: 1'b0};

    // Advance one DCL rising edge
    function automatic slot_pos_t pos_step(slot_pos_t p, cell_mode_e mode, slot_t last_slot);
        slot_pos_t n;
        n = p;
        if (p.in_frame) begin
            if (mode == CELL_DOUBLE && !p.half) begin
                n.half = 1'b1;
            end else begin
                n.half = 1'b0;
                if (p.bitn == bitidx_t'(TSP_WORD_W - 1)) begin
                    n.bitn = '0;
                    if (p.slot == last_slot) begin
                        n.in_frame = 1'b0;
                        n.slot     = '0;
                    end else begin
                        n.slot = p.slot + slot_t'(1);
                    end
                end else begin
                    n.bitn = p.bitn + bitidx_t'(1);
                end
            end
        end
        return n;
    endfunction

    function automatic slot_t clamp_slots(slot_t req, slot_t lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/tsp_edge_sense.sv
module tsp_edge_sense
    import tsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dcl,
    input  logic      fsc,
    output line_evt_t evt
);

    logic dcl_q;
    logic fsc_at_rise;

    always_comb begin
        evt.rise        = dcl & ~dcl_q;
        evt.fall        = ~dcl & dcl_q;
        evt.frame_start = dcl & ~dcl_q & fsc & ~fsc_at_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dcl_q       <= 1'b0;
            fsc_at_rise <= 1'b0;
        end else begin
            dcl_q <= dcl;
            if (evt.rise) begin
                fsc_at_rise <= fsc;
            end
        end
    end

    // R3: two frame starts never come from consecutive clock cycles
    a_r3_no_back_to_back_start: assert property (@(posedge clk) disable iff (rst)
        evt.frame_start |=> !evt.frame_start);

endmodule

// File: rtl/tsp_slot_tracker.sv
module tsp_slot_tracker
    import tsp_pkg::*;
#(
    parameter int MAX_SLOTS = 16
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  logic       frame_start,
    input  cell_mode_e mode,
    output slot_pos_t  pos,
    output slot_pos_t  pos_nxt
);

    localparam slot_t LAST_SLOT = slot_t'(MAX_SLOTS - 1);

    always_comb begin
        if (frame_start) begin
            pos_nxt = POS_START;
        end else if (rise) begin
            pos_nxt = pos_step(pos, mode, LAST_SLOT);
        end else begin
            pos_nxt = pos;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else begin
            pos <= pos_nxt;
        end
    end

    // R3: a frame start lands on slot 0, bit 0, first half
    a_r3_start_aligns: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (pos.in_frame && pos.slot == '0 && pos.bitn == '0 && !pos.half));

    // R10: the slot index never passes the last slot
    a_r10_slot_bounded: assert property (@(posedge clk) disable iff (rst)
        pos.in_frame |-> (pos.slot <= LAST_SLOT));

    // R10: leaving the frame needs a rising edge at the last slot
    a_r10_leave_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(pos.in_frame) |-> $past(pos.slot == LAST_SLOT && rise));

endmodule

// File: rtl/tsp_tx_path.sv
module tsp_tx_path
    import tsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rise,
    input  slot_pos_t pos_nxt,
    input  slot_t     act_lim,
    input  word_t     tx_data,
    output logic      txd,
    output logic      tx_take,
    output slot_t     tx_take_slot
);

    word_t tx_sr;
    logic  launch;
    logic  live;

    always_comb begin
        launch = rise && !pos_nxt.half;
        live   = pos_nxt.in_frame && (pos_nxt.slot < act_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txd          <= 1'b1;
            tx_sr        <= '0;
            tx_take      <= 1'b0;
            tx_take_slot <= '0;
        end else begin
            tx_take <= 1'b0;
            if (launch) begin
                if (live) begin
                    if (pos_nxt.bitn == '0) begin
                        txd          <= tx_data[TSP_WORD_W-1];
                        tx_sr        <= {tx_data[TSP_WORD_W-2:0], 1'b0};
                        tx_take      <= 1'b1;
                        tx_take_slot <= pos_nxt.slot;
                    end else begin
                        txd   <= tx_sr[TSP_WORD_W-1];
                        tx_sr <= {tx_sr[TSP_WORD_W-2:0], 1'b0};
                    end
                end else begin
                    txd <= 1'b1;
                end
            end
        end
    end

    // R4: the line only moves after a DCL rising edge
    a_r4_txd_on_rise: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(txd));

    // R11: the second rise of a double cell leaves the bit alone
    a_r11_hold_second_rise: assert property (@(posedge clk) disable iff (rst)
        (rise && pos_nxt.half) |=> $stable(txd));

    // R8: words are only taken for active slots
    a_r8_take_in_range: assert property (@(posedge clk) disable iff (rst)
        tx_take |-> (tx_take_slot < $past(act_lim)));

endmodule

// File: rtl/tsp_rx_path.sv
module tsp_rx_path
    import tsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fall,
    input  slot_pos_t  pos,
    input  cell_mode_e mode,
    input  slot_t      act_lim,
    input  logic       rxd,
    output word_t      rx_word,
    output slot_t      rx_slot,
    output logic       rx_valid
);

    logic [TSP_WORD_W-2:0] rx_sr;
    logic                  sample;

    always_comb begin
        sample = fall && pos.in_frame && (pos.slot < act_lim)
                 && (mode == CELL_SINGLE || pos.half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr    <= '0;
            rx_word  <= '0;
            rx_slot  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample) begin
                rx_sr <= {rx_sr[TSP_WORD_W-3:0], rxd};
                if (pos.bitn == bitidx_t'(TSP_WORD_W - 1)) begin
                    rx_word  <= {rx_sr, rxd};
                    rx_slot  <= pos.slot;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // R7: the delivery strobe lasts one cycle
    a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R6: a word is completed by a falling DCL edge
    a_r6_valid_after_fall: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(fall));

endmodule

// File: rtl/tsp_serial_port.sv
module tsp_serial_port
    import tsp_pkg::*;
#(
    parameter int MAX_SLOTS = 16
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dcl,
    input  logic                  fsc,
    input  logic                  double_mode,
    input  logic [TSP_SLOT_W-1:0] active_slots,
    input  logic [TSP_WORD_W-1:0] tx_data,
    output logic                  tx_take,
    output logic [TSP_SLOT_W-1:0] tx_take_slot,
    output logic                  txd,
    input  logic                  rxd,
    output logic [TSP_WORD_W-1:0] rx_word,
    output logic [TSP_SLOT_W-1:0] rx_slot,
    output logic                  rx_valid
);

    localparam slot_t SLOT_LIMIT = slot_t'(MAX_SLOTS);

    line_evt_t  evt;
    slot_pos_t  pos;
    slot_pos_t  pos_nxt;
    cell_mode_e mode;
    slot_t      act_lim;

    always_comb begin
        mode    = cell_mode_e'(double_mode);
        act_lim = clamp_slots(active_slots, SLOT_LIMIT);
    end

    tsp_edge_sense u_edge (
        .clk (clk),
        .rst (rst),
        .dcl (dcl),
        .fsc (fsc),
        .evt (evt)
    );

    tsp_slot_tracker #(.MAX_SLOTS(MAX_SLOTS)) u_track (
        .clk         (clk),
        .rst         (rst),
        .rise        (evt.rise),
        .frame_start (evt.frame_start),
        .mode        (mode),
        .pos         (pos),
        .pos_nxt     (pos_nxt)
    );

    tsp_tx_path u_tx (
        .clk          (clk),
        .rst          (rst),
        .rise         (evt.rise),
        .pos_nxt      (pos_nxt),
        .act_lim      (act_lim),
        .tx_data      (tx_data),
        .txd          (txd),
        .tx_take      (tx_take),
        .tx_take_slot (tx_take_slot)
    );

    tsp_rx_path u_rx (
        .clk      (clk),
        .rst      (rst),
        .fall     (evt.fall),
        .pos      (pos),
        .mode     (mode),
        .act_lim  (act_lim),
        .rxd      (rxd),
        .rx_word  (rx_word),
        .rx_slot  (rx_slot),
        .rx_valid (rx_valid)
    );

    // R5: a frame start with any active slot takes the word for slot 0
    a_r5_start_takes_slot0: assert property (@(posedge clk) disable iff (rst)
        (evt.frame_start && act_lim != '0) |=> (tx_take && tx_take_slot == '0));

    // R8: with nothing active, no strobe appears
    a_r8_zero_active_silent: assert property (@(posedge clk) disable iff (rst)
        (act_lim == '0 && $past(act_lim == '0)) |-> (!tx_take && !rx_valid));

endmodule

// File: tb/tb_tsp_serial_port.sv
module tb_tsp_serial_port;
    import tsp_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic  rst = 1'b1;
    logic  dcl = 1'b0;
    logic  fsc = 1'b0;
    logic  double_mode = 1'b0;
    slot_t active_slots = '0;
    word_t tx_data = '0;
    logic  tx_take;
    slot_t tx_take_slot;
    logic  txd;
    logic  rxd = 1'b1;
    word_t rx_word;
    slot_t rx_slot;
    logic  rx_valid;

    tsp_serial_port #(.MAX_SLOTS(16)) dut (
        .clk          (clk),
        .rst          (rst),
        .dcl          (dcl),
        .fsc          (fsc),
        .double_mode  (double_mode),
        .active_slots (active_slots),
        .tx_data      (tx_data),
        .tx_take      (tx_take),
        .tx_take_slot (tx_take_slot),
        .txd          (txd),
        .rxd          (rxd),
        .rx_word      (rx_word),
        .rx_slot      (rx_slot),
        .rx_valid     (rx_valid)
    );

    typedef struct {
        slot_t s;
        word_t w;
    } rx_item_t;

    rx_item_t rx_q[$];
    slot_t    take_q[$];
    int       checks = 0;
    int       errors = 0;
    bit       done = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic word_t txw(int f, int s);
        logic [31:0] v;
        v = 32'h0000_9A61 ^ (s * 32'h0000_0B13) ^ (f * 32'h0000_4C27);
        return v[15:0];
    endfunction

    function automatic word_t rxw(int f, int s);
        logic [31:0] v;
        v = 32'h0000_3E85 ^ (s * 32'h0000_1D09) ^ (f * 32'h0000_62B1);
        return v[15:0];
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                if (rx_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected rx_valid slot", int'(rx_slot), -1);
                end else begin
                    rx_item_t e;
                    e = rx_q.pop_front();
                    chk(rx_slot == e.s, "R7", "rx_slot", int'(rx_slot), int'(e.s));
                    chk(rx_word == e.w, "R6", "rx_word", int'(rx_word), int'(e.w));
                end
            end
            if (tx_take) begin
                if (take_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected tx_take slot", int'(tx_take_slot), -1);
                end else begin
                    slot_t es;
                    es = take_q.pop_front();
                    chk(tx_take_slot == es, "R5", "tx_take_slot", int'(tx_take_slot), int'(es));
                end
            end
        end
    end

    task automatic edge_to(bit lvl, bit rv);
        @(negedge clk);
        dcl = lvl;
        rxd = rv;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_bit(int f, int s, int k, bit dbl, int act, bit start, bit full_slot);
        bit e;
        bit b;
        int act_eff;
        word_t tw;
        word_t rw;
        act_eff = (act > 16) ? 16 : act;
        tw = txw(f, s);
        rw = rxw(f, s);
        b = rw[15-k];
        e = (s < act_eff) ? tw[15-k] : 1'b1;
        if (k == 0 && s < act_eff) begin
            tx_data = tw;
            take_q.push_back(slot_t'(s));
            if (full_slot) begin
                rx_q.push_back('{s: slot_t'(s), w: rw});
            end
        end
        fsc = start;
        if (!dbl) begin
            edge_to(1'b1, ~b);
            chk(txd == e, (s < act_eff) ? "R4" : "R8", "txd single", int'(txd), int'(e));
            edge_to(1'b0, b);
            fsc = 1'b0;
        end else begin
            edge_to(1'b1, ~b);
            chk(txd == e, (s < act_eff) ? "R4" : "R8", "txd double first", int'(txd), int'(e));
            edge_to(1'b0, ~b);
            fsc = 1'b0;
            edge_to(1'b1, b);
            chk(txd == e, "R11", "txd double second", int'(txd), int'(e));
            edge_to(1'b0, b);
        end
    endtask

    task automatic idle_bit(string req);
        edge_to(1'b1, 1'b0);
        chk(txd == 1'b1, req, "txd idle", int'(txd), 1);
        edge_to(1'b0, 1'b0);
    endtask

    task automatic run_frame(int f, bit dbl, int act, int nslots, int last_bits);
        double_mode  = dbl;
        active_slots = slot_t'(act);
        for (int s = 0; s < nslots; s++) begin
            int nb;
            nb = (s == nslots - 1) ? last_bits : 16;
            for (int k = 0; k < nb; k++) begin
                run_bit(f, s, k, dbl, act, (s == 0 && k == 0), nb == 16);
            end
        end
    endtask

    task automatic drain(string req);
        repeat (8) @(negedge clk);
        chk(rx_q.size() == 0, req, "rx words missing", rx_q.size(), 0);
        chk(take_q.size() == 0, "R5", "takes missing", take_q.size(), 0);
        rx_q.delete();
        take_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
        chk(rx_valid == 1'b0, "R1", "rx_valid in reset", int'(rx_valid), 0);
        chk(tx_take == 1'b0, "R1", "tx_take in reset", int'(tx_take), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);

        // R2: clocks without a frame sync
        active_slots = slot_t'(4);
        for (int i = 0; i < 4; i++) idle_bit("R2");
        drain("R2");

        // R4 R6: single cell, twelve slots
        run_frame(1, 1'b0, 12, 12, 16);
        drain("R7");
        // R11 R6: double cell, six slots
        run_frame(2, 1'b1, 6, 6, 16);
        drain("R6");
        // R8: slots past the active count
        run_frame(3, 1'b0, 3, 5, 16);
        drain("R8");
        run_frame(4, 1'b1, 2, 3, 16);
        drain("R8");
        // R8 clamp and R10 idle after last slot
        run_frame(5, 1'b0, 20, 16, 16);
        for (int i = 0; i < 4; i++) idle_bit("R10");
        drain("R10");
        // R9: early frame sync mid slot
        run_frame(6, 1'b0, 4, 2, 7);
        run_frame(7, 1'b0, 4, 4, 16);
        drain("R9");
        // R8: zero active slots
        run_frame(8, 1'b0, 0, 2, 16);
        drain("R8");

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule